// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects interrupt events for a small microcontroller core. Nine sources are modelled as one-cycle input pulses. Each pulse sets its own request flag. Seven sources are vectored and sit on six priority levels. Source 0 and source 1 share level 1. Sources 2 to 6 are on levels 2 to 6, with level 1 the most urgent. Sources 7 and 8 are poll-only: they set a flag that software reads and clears, and they never produce a vector.

A vectored flag is eligible when its per-source enable is set and the master enable is set. Among eligible flags, the lowest source index wins, which gives level order and puts source 0 ahead of source 1 inside level 1. The winner is locked and offered on a valid/ready channel as a vector-table address equal to twice its level (0x0002 to 0x000C). While `irq_valid` is high and `irq_ready` is low, the offer is held unchanged. The handshake completes in a cycle where both are high. That cycle clears the serviced source's flag and drops the master enable. A 3-bit priority-select value P allows nesting: after a level above P is taken, levels 1..P stay eligible without the master enable until one of them is taken. Any flag whose enable is set drives the standby wake output, whatever the master enable.

Software reaches the flags through a 2-bit register port:
- Address 0 is write-1-to-set for the flags and reads the flags.
- Address 1 is write-1-to-clear for the flags and reads the flags.
- Address 2 holds the enables.
- Address 3 holds control: bit 0 master, bits 3:1 P, bit 4 nest-armed (read only).

Top module: `vpic_top`

## Requirements
- R1: After reset all flags, enables and control bits read 0. A pulse on `src_pulse[i]` sets flag bit i, which reads back at address 0 from the next cycle.
- R2: A vectored flag leads to `irq_valid` only when its enable bit (address 2, bit i) and the master bit (address 3, bit 0) are both 1. The vector is 2×level: sources 0 and 1 give 0x0002, and source k (k = 2..6) gives 2k. Valid rises two clock edges after the pulse.
- R3: When several eligible flags are pending, the lowest source index is offered. This means the lowest level wins, and source 0 is taken before source 1.
- R4: While `irq_valid` is high and `irq_ready` is low, `irq_valid` stays high and `irq_vector` stays unchanged.
- R5: A completed handshake clears only the serviced source's flag. The other level-1 flag stays set.
- R6: A completed handshake clears the master bit.
- R7: With P = address 3 bits 3:1, taking a level above P arms nesting (address 3 bit 4). While armed, enabled levels 1..P are offered with the master bit clear. Taking any level at or below P disarms it and leaves only the master bit as a path. P = 0 never nests.
- R8: Sources 7 and 8 set flags but never raise `irq_valid`. A write of 1 to address 1 clears the chosen flags.
- R9: `wake` is 1 exactly when some flag has its enable set, regardless of the master bit.
- R10: A write of 1 to a bit at address 0 sets that flag like a pulse.
- R11: A write to address 3 loads master and P and clears the nest-armed bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| src_pulse | input | 9 | one-cycle event pulses, one per source |
| reg_we | input | 1 | register write strobe |
| reg_addr | input | 2 | register address |
| reg_wdata | input | 9 | register write data |
| reg_rdata | output | 9 | register read data (combinational on reg_addr) |
| irq_valid | output | 1 | vector offer valid |
| irq_ready | input | 1 | CPU accepts the offered vector |
| irq_vector | output | 16 | vector-table address of the offer |
| wake | output | 1 | standby release request |

## Verification
The bench sweeps every pair of simultaneous vectored sources, including the shared level-1 pair. A design with the wrong tie order would offer 0x0002 but then clear the wrong flag. A design that cleared both shared flags would lose the second event. It sweeps every mask position with the master set and clear. A design that ignored an enable would vector, and one that gated wake with the master would stay asleep. It runs every combination of P, first level and second level, so an off-by-one compare with P, or nesting that never disarms, shows up as a missing or extra offer. Poll-only sources are checked to never produce a vector.

// File: rtl/vpic_pkg.sv
package vpic_pkg;
  localparam int NSRC    = 9;
  localparam int NVEC    = 7;
  localparam int LVL_W   = 3;
  localparam int IDX_W   = $clog2(NSRC);
  localparam int ADDR_W  = 2;
  localparam int CTL_W   = LVL_W + 2;

  localparam logic [ADDR_W-1:0] A_SET = 2'd0;
  localparam logic [ADDR_W-1:0] A_CLR = 2'd1;
  localparam logic [ADDR_W-1:0] A_EN  = 2'd2;
  localparam logic [ADDR_W-1:0] A_CTL = 2'd3;

  // Level of a source: 0 means poll-only (never vectored).
  function automatic logic [LVL_W-1:0] src_level(input int idx);
    if (idx <= 1)         return LVL_W'(1);
    else if (idx < NVEC)  return LVL_W'(idx);
    else                  return '0;
  endfunction
endpackage

// File: rtl/vpic_flags.sv
module vpic_flags
  import vpic_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   pulse,
  input  logic              sw_we,
  input  logic [ADDR_W-1:0] sw_addr,
  input  logic [NSRC-1:0]   sw_wdata,
  input  logic              clr_en,
  input  logic [IDX_W-1:0]  clr_idx,
  output logic [NSRC-1:0]   flags,
  output logic [NSRC-1:0]   enables
);
  logic [NSRC-1:0] flag_nxt;

  always_comb begin
    flag_nxt = flags;
    if (sw_we && sw_addr == A_CLR) flag_nxt = flag_nxt & ~sw_wdata;
    if (clr_en)                    flag_nxt[clr_idx] = 1'b0;
    if (sw_we && sw_addr == A_SET) flag_nxt = flag_nxt | sw_wdata;
    flag_nxt = flag_nxt | pulse;   // a fresh event is never lost
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags   <= '0;
      enables <= '0;
    end else begin
      flags <= flag_nxt;
      if (sw_we && sw_addr == A_EN) enables <= sw_wdata;
    end
  end

  // R1: every pulsed source shows its flag on the next cycle
  a_r1_pulse_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse != '0) |=> ((flags & $past(pulse)) == $past(pulse)));

  // R5: a handshake alone removes exactly one flag
  a_r5_single_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && pulse == '0 && !sw_we) |=>
      (flags == ($past(flags) & ~(NSRC'(1) << $past(clr_idx)))));
endmodule

// File: rtl/vpic_ctrl.sv
module vpic_ctrl
  import vpic_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_we,
  input  logic [ADDR_W-1:0] sw_addr,
  input  logic [CTL_W-2:0]  sw_wdata,
  input  logic              ack,
  input  logic [LVL_W-1:0]  ack_level,
  output logic              master,
  output logic [LVL_W-1:0]  prio,
  output logic              armed
);
  logic ack_high;
  assign ack_high = (ack_level <= prio);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      master <= 1'b0;
      prio   <= '0;
      armed  <= 1'b0;
    end else begin
      if (sw_we && sw_addr == A_CTL) begin
        master <= sw_wdata[0];
        prio   <= sw_wdata[LVL_W:1];
        armed  <= 1'b0;
      end
      if (ack) begin
        master <= 1'b0;
        armed  <= ~ack_high;
      end
    end
  end

  // R6: master is always gone after a handshake
  a_r6_ack_drops_master: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !master);

  // R11: a control write with no handshake disarms nesting
  a_r11_write_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_we && sw_addr == A_CTL && !ack) |=> !armed);
endmodule

// File: rtl/vpic_pick.sv
module vpic_pick
  import vpic_pkg::*;
(
  input  logic [NSRC-1:0]  flags,
  input  logic [NSRC-1:0]  enables,
  input  logic             master,
  input  logic [LVL_W-1:0] prio,
  input  logic             armed,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  logic [NSRC-1:0] elig;

  for (genvar g = 0; g < NSRC; g++) begin : g_elig
    localparam logic [LVL_W-1:0] LV = src_level(g);
    if (LV == '0) begin : g_poll
      assign elig[g] = 1'b0;
    end else begin : g_vec
      assign elig[g] = flags[g] && enables[g] && (master || (armed && LV <= prio));
    end
  end

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (elig[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/vpic_port.sv
module vpic_port
  import vpic_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             found,
  input  logic [IDX_W-1:0] pick_idx,
  input  logic             ready,
  output logic             valid,
  output logic [IDX_W-1:0] lock_idx,
  output logic             ack
);
  assign ack = valid && ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid    <= 1'b0;
      lock_idx <= '0;
    end else if (!valid) begin
      if (found) begin
        valid    <= 1'b1;
        lock_idx <= pick_idx;
      end
    end else if (ready) begin
      valid <= 1'b0;
    end
  end

  // R4: an offer is held until it is taken
  a_r4_hold_offer: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(lock_idx)));

  // R3: the locked source is the one the picker chose
  a_r3_lock_choice: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid && found) |=> (valid && lock_idx == $past(pick_idx)));
endmodule

// File: rtl/vpic_top.sv
module vpic_top
  import vpic_pkg::*;
#(
  parameter int VEC_W    = 16,
  parameter int VEC_STEP = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_pulse,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [NSRC-1:0]   reg_wdata,
  output logic [NSRC-1:0]   reg_rdata,
  output logic              irq_valid,
  input  logic              irq_ready,
  output logic [VEC_W-1:0]  irq_vector,
  output logic              wake
);
  logic [NSRC-1:0]  flags, enables;
  logic             master, armed, found, ack;
  logic [LVL_W-1:0] prio, lock_lvl;
  logic [IDX_W-1:0] pick_idx, lock_idx;

  vpic_flags u_flags (
    .clk(clk), .rst_n(rst_n), .pulse(src_pulse),
    .sw_we(reg_we), .sw_addr(reg_addr), .sw_wdata(reg_wdata),
    .clr_en(ack), .clr_idx(lock_idx),
    .flags(flags), .enables(enables));

  vpic_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .sw_we(reg_we), .sw_addr(reg_addr), .sw_wdata(reg_wdata[CTL_W-2:0]),
    .ack(ack), .ack_level(lock_lvl),
    .master(master), .prio(prio), .armed(armed));

  vpic_pick u_pick (
    .flags(flags), .enables(enables), .master(master), .prio(prio),
    .armed(armed), .found(found), .idx(pick_idx));

  vpic_port u_port (
    .clk(clk), .rst_n(rst_n), .found(found), .pick_idx(pick_idx),
    .ready(irq_ready), .valid(irq_valid), .lock_idx(lock_idx), .ack(ack));

  assign lock_lvl   = src_level(int'(lock_idx));
  assign irq_vector = VEC_W'(lock_lvl) * VEC_W'(VEC_STEP);
  assign wake       = |(flags & enables);

  always_comb begin
    case (reg_addr)
      A_EN:    reg_rdata = enables;
      A_CTL:   reg_rdata = NSRC'({armed, prio, master});
      default: reg_rdata = flags;
    endcase
  end

  // R2: an offered vector is one of the six level slots
  a_r2_vec_legal: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (irq_vector >= VEC_W'(VEC_STEP) &&
                   irq_vector <= VEC_W'(VEC_STEP * (NVEC - 1)) &&
                   irq_vector % VEC_W'(VEC_STEP) == '0));

  // R8: poll-only sources are never offered
  a_r8_no_poll_offer: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (int'(lock_idx) < NVEC));

  // R9: wake never rises without some flag set
  a_r9_wake_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> (flags != '0));
endmodule

// File: tb/vpic_top_test.sv
module vpic_top_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [8:0] src_pulse = '0;
  logic       reg_we = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [8:0] reg_wdata = '0;
  logic [8:0] reg_rdata;
  logic       irq_valid;
  logic       irq_ready = 1'b0;
  logic [15:0] irq_vector;
  logic       wake;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  vpic_top uut (
    .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_valid(irq_valid), .irq_ready(irq_ready),
    .irq_vector(irq_vector), .wake(wake));

  function automatic int lvl(input int s);
    if (s <= 1) return 1;
    if (s <= 6) return s;
    return 0;
  endfunction

  function automatic int src_of(input int l);
    return (l == 1) ? 0 : l;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    reg_we = 1'b1; reg_addr = 2'(a); reg_wdata = 9'(d);
    tick;
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input int a, output int v);
    reg_addr = 2'(a);
    #1;
    v = int'(reg_rdata);
  endtask

  task automatic pulse(input int m);
    src_pulse = 9'(m);
    tick;
    src_pulse = '0;
  endtask

  task automatic take;
    irq_ready = 1'b1;
    tick;
    irq_ready = 1'b0;
  endtask

  task automatic clean;
    wr(3, 0);
    wr(1, 9'h1FF);
    if (irq_valid) take;
    wr(1, 9'h1FF);
    tick;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int v;
    tick; tick;
    rst_n = 1'b1;
    tick;
    // R1 reset state
    rd(0, v); chk(v == 0, "R1 flags at reset", v, 0);
    rd(2, v); chk(v == 0, "R1 enables at reset", v, 0);
    rd(3, v); chk(v == 0, "R1 control at reset", v, 0);
    chk(!irq_valid && !wake, "R1 outputs at reset", {irq_valid, wake}, 0);

    // single sources, all enabled, master on
    for (int s = 0; s < 9; s++) begin
      clean;
      wr(2, 9'h1FF); wr(3, 1);
      pulse(1 << s);
      rd(0, v); chk(v == (1 << s), "R1 flag set by pulse", v, 1 << s);
      tick;
      chk(irq_valid == (s <= 6), "R2/R8 valid for source", irq_valid, s <= 6);
      chk(wake == 1'b1, "R9 wake with enabled flag", wake, 1);
      if (s <= 6) begin
        chk(irq_vector == 16'(2 * lvl(s)), "R2 vector slot", irq_vector, 2 * lvl(s));
        tick;
        chk(irq_valid && irq_vector == 16'(2 * lvl(s)), "R4 offer held", irq_vector, 2 * lvl(s));
        take;
        rd(0, v); chk(v == 0, "R5 flag cleared on handshake", v, 0);
        rd(3, v); chk((v & 1) == 0, "R6 master cleared", v & 1, 0);
      end else begin
        wr(1, 1 << s);
        rd(0, v); chk(v == 0, "R8 software clear", v, 0);
      end
    end

    // software set (R10) and control readback (R11)
    for (int s = 0; s < 9; s++) begin
      clean;
      wr(0, 1 << s);
      rd(0, v); chk(v == (1 << s), "R10 software set", v, 1 << s);
    end
    clean;
    wr(3, 9'h0B);
    rd(3, v); chk(v == 9'h0B, "R11 control load", v, 9'h0B);

    // masking: enable off, and master off
    for (int s = 0; s <= 6; s++) begin
      clean;
      wr(2, ~(1 << s) & 9'h1FF); wr(3, 1);
      pulse(1 << s); tick; tick;
      chk(!irq_valid, "R2 masked by enable", irq_valid, 0);
      chk(!wake, "R9 no wake when disabled", wake, 0);
      clean;
      wr(2, 9'h1FF);
      pulse(1 << s); tick; tick;
      chk(!irq_valid, "R2 masked by master", irq_valid, 0);
      chk(wake, "R9 wake without master", wake, 1);
      wr(3, 1); tick;
      chk(irq_valid && irq_vector == 16'(2 * lvl(s)), "R11 master write releases", irq_vector, 2 * lvl(s));
      take;
    end

    // every simultaneous pair of vectored sources
    for (int a = 0; a <= 6; a++) begin
      for (int b = 0; b <= 6; b++) begin
        if (a != b) begin
          int win, lose;
          win  = (a < b) ? a : b;
          lose = (a < b) ? b : a;
          clean;
          wr(2, 9'h1FF); wr(3, 1);
          pulse((1 << a) | (1 << b)); tick;
          chk(irq_valid && irq_vector == 16'(2 * lvl(win)), "R3 pair winner", irq_vector, 2 * lvl(win));
          take;
          rd(0, v); chk(v == (1 << lose), "R5 loser flag kept", v, 1 << lose);
          wr(3, 1); tick;
          chk(irq_valid && irq_vector == 16'(2 * lvl(lose)), "R3 loser next", irq_vector, 2 * lvl(lose));
          take;
        end
      end
    end

    // nesting under priority select
    for (int p = 0; p <= 6; p++) begin
      for (int l = 1; l <= 6; l++) begin
        for (int m = 1; m <= 6; m++) begin
          if (m != l) begin
            bit exp_arm, exp_take;
            exp_arm  = (l > p);
            exp_take = (l > p) && (m <= p);
            clean;
            wr(2, 9'h1FF); wr(3, (p << 1) | 1);
            pulse(1 << src_of(l)); tick;
            take;
            rd(3, v);
            chk(v == ((int'(exp_arm) << 4) | (p << 1)), "R7 armed state", v, (int'(exp_arm) << 4) | (p << 1));
            pulse(1 << src_of(m)); tick;
            chk(irq_valid == exp_take, "R7 nested offer", irq_valid, exp_take);
            if (exp_take) begin
              chk(irq_vector == 16'(2 * m), "R7 nested vector", irq_vector, 2 * m);
              take;
              rd(3, v); chk(v == (p << 1), "R7 disarm after high", v, p << 1);
            end
          end
        end
      end
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule